// File: doc/BRIEF.md
# Key-Locked Control Register File

A bank of 32-bit control and status registers on a plain word bus: one byte address, separate read and write strobes, a write data word and a registered read data word. One register holds a protection key. While that key register holds one exact magic word, the whole bank can be written. Any other value locks a fixed low window of registers, and writes there are discarded.

Some registers are read-only and drop all writes. One register is write-only: reading it is flagged, but its stored value is still returned. At reset every register loads its own default value. The revision register and two strap registers are loaded from input ports instead. Accesses outside the implemented array are flagged. Every flagged access gives a one-cycle error pulse with a two-bit cause code, so a monitor can log the event.

Top module: `keyed_ctrl_regs`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) loads the defaults: 0xFFCFFEDC at byte offset 0x04, 0x00000001 at 0x3C, 0x00002402 at 0x1A4, and zero in every other register not named in R2. During reset, err_pulse and rdata are 0.
- R2: The same reset loads rev_id into the register at 0x7C, strap_lo into 0x70 and strap_hi into 0xD0.
- R3: The key register at offset 0x00 accepts any write at any time and reads back the last value written.
- R4: The bank is unlocked only while the key register equals 0x1688A8A8. While it is locked, a write to any offset from 0x04 to 0xFC is discarded and flagged with cause 2'b01.
- R5: Registers at offset 0x100 and above (inside the array) accept writes whether the bank is locked or not.
- R6: A write to a read-only register is discarded and flagged with cause 2'b10. The read-only registers are 0x14, 0x50 to 0x6C, 0x78, 0x7C, 0xE0 and 0xE4. On a locked write to one of these offsets, the lock check is applied first, so the cause is 2'b01.
- R7: A read of the write-only register at 0xC0 returns its stored value and is flagged with cause 2'b11. Writes to 0xC0 are accepted when the bank is unlocked.
- R8: An out-of-range access is flagged with cause 2'b00. An access is out of range if its word index (address >> 2) is 106 or more, or if address bits [1:0] are not zero. Such a read returns 0 and such a write changes nothing.
- R9: Read data appears on rdata in the cycle after rd_en and holds until the next read. A read and a write to the same address in the same cycle return the old value.
- R10: The lock check uses the key value held before the current cycle's write. A key write takes effect for accesses in the following cycle.
- R11: err_pulse is high for exactly the one cycle after a flagged access, with err_cause valid alongside it. When the write and the read of the same cycle are both flagged, the write's cause is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rev_id | input | 32 | Revision value loaded at reset |
| strap_lo | input | 32 | First strap value loaded at reset |
| strap_hi | input | 32 | Second strap value loaded at reset |
| err_pulse | output | 1 | One-cycle access error flag |
| err_cause | output | 2 | 00 range, 01 locked, 10 read-only, 11 write-only |

## Verification
The bench targets the edges of the protected window:
- A design with an off-by-one window would lock 0x100 or leave 0xFC open.
- A design that compares the key too loosely would unlock on a near-miss value one bit away from the magic word.
- A design that uses the incoming key write for the lock check would accept a protected write in the same cycle as the key write.

It also writes every kind of read-only register, looking for one that silently stores data. It reads 0xC0 to catch a design that returns zero for the write-only register. It issues read and write together, where a wrong design would forward the new data or report the read's cause over the write's. Unaligned and too-high addresses check that nothing aliases into the array.

// File: rtl/keyed_ctrl_regs.sv
module keyed_ctrl_regs #(
  parameter int ADDR_W = 12,
  parameter int NREGS = 106,
  parameter logic [31:0] KEY = 32'h1688A8A8,
  parameter int OPEN_FIRST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       rev_id,
  input  logic [31:0]       strap_lo,
  input  logic [31:0]       strap_hi,
  output logic              err_pulse,
  output logic [1:0]        err_cause
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int AW = $clog2(NREGS);
  localparam logic [IDX_W-1:0] I_FREQ = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_SCR_LO = IDX_W'(20);
  localparam logic [IDX_W-1:0] I_SCR_HI = IDX_W'(27);
  localparam logic [IDX_W-1:0] I_RNG = IDX_W'(30);
  localparam logic [IDX_W-1:0] I_REV = IDX_W'(31);
  localparam logic [IDX_W-1:0] I_CNT_A = IDX_W'(56);
  localparam logic [IDX_W-1:0] I_CNT_B = IDX_W'(57);
  localparam logic [IDX_W-1:0] I_WO = IDX_W'(48);
  localparam int I_STRAP_LO = 28;
  localparam int I_STRAP_HI = 52;

  function automatic logic [31:0] rst_val(input int i);
    case (i)
      1:       return 32'hFFCFFEDC;
      15:      return 32'h00000001;
      105:     return 32'h00002402;
      default: return 32'h0;
    endcase
  endfunction

  logic [31:0] mem [NREGS];

  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    widx;
  logic in_rng, unlocked, prot, ro, wr_lock, wr_ro, wr_ok, wr_rng, rd_rng, rd_wo;

  assign idx      = addr[ADDR_W-1:2];
  assign widx     = idx[AW-1:0];
  assign in_rng   = (addr[1:0] == 2'b00) && (idx < IDX_W'(NREGS));
  assign unlocked = (mem[0] == KEY);
  assign prot     = (idx != '0) && (idx < IDX_W'(OPEN_FIRST));
  assign ro       = (idx == I_FREQ) || ((idx >= I_SCR_LO) && (idx <= I_SCR_HI)) ||
                    (idx == I_RNG) || (idx == I_REV) || (idx == I_CNT_A) || (idx == I_CNT_B);

  assign wr_rng  = wr_en && !in_rng;
  assign wr_lock = wr_en && in_rng && prot && !unlocked;
  assign wr_ro   = wr_en && in_rng && !wr_lock && ro;
  assign wr_ok   = wr_en && in_rng && !wr_lock && !ro;
  assign rd_rng  = rd_en && !in_rng;
  assign rd_wo   = rd_en && in_rng && (idx == I_WO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= rst_val(i);
      mem[I_REV]      <= rev_id;
      mem[I_STRAP_LO] <= strap_lo;
      mem[I_STRAP_HI] <= strap_hi;
      rdata     <= '0;
      err_pulse <= 1'b0;
      err_cause <= 2'b00;
    end else begin
      if (wr_ok) mem[widx] <= wdata;
      if (rd_en) rdata <= in_rng ? mem[widx] : '0;
      err_pulse <= wr_rng || wr_lock || wr_ro || rd_rng || rd_wo;
      if (wr_rng)       err_cause <= 2'b00;
      else if (wr_lock) err_cause <= 2'b01;
      else if (wr_ro)   err_cause <= 2'b10;
      else if (rd_rng)  err_cause <= 2'b00;
      else if (rd_wo)   err_cause <= 2'b11;
    end
  end
endmodule

module keyed_ctrl_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int NREGS = 106,
  parameter logic [31:0] KEY = 32'h1688A8A8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              err_pulse,
  input logic [1:0]        err_cause,
  input logic [31:0]       key
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] cidx;
  logic c_oor, c_prot, c_zero;
  assign cidx   = addr[ADDR_W-1:2];
  assign c_oor  = (addr[1:0] != 2'b00) || (cidx >= IDX_W'(NREGS));
  assign c_prot = !c_oor && (cidx != '0) && (cidx < IDX_W'(64));
  assign c_zero = (addr == '0);

  // R11
  err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(rd_en || wr_en));
  // R8
  oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && c_oor) |=> (rdata == 32'h0) && err_pulse);
  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && c_prot && (key != KEY)) |=> err_pulse && (err_cause == 2'b01));
  // R7
  wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && (addr == ADDR_W'(12'h0C0))) |=> err_pulse && (err_cause == 2'b11));
  // R3
  key_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && c_zero) |=> (key == $past(wdata)));
endmodule

bind keyed_ctrl_regs keyed_ctrl_regs_chk #(.ADDR_W(ADDR_W), .NREGS(NREGS), .KEY(KEY)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .err_pulse(err_pulse), .err_cause(err_cause),
  .key(mem[0])
);

// File: tb/keyed_ctrl_regs_tb.sv
module keyed_ctrl_regs_tb_top;
  localparam int AW = 12;
  localparam int N = 106;
  localparam logic [31:0] MAGIC = 32'h1688A8A8;
  localparam logic [31:0] REV = 32'hA0000303;
  localparam logic [31:0] SLO = 32'h12345678;
  localparam logic [31:0] SHI = 32'hCAFE0001;

  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic err_pulse;
  logic [1:0] err_cause;
  always #4 clk = ~clk;

  keyed_ctrl_regs dut_i (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rev_id(REV), .strap_lo(SLO), .strap_hi(SHI),
    .err_pulse(err_pulse), .err_cause(err_cause));

  int tests = 0, fails = 0;
  logic [31:0] m [N];
  logic [31:0] exp_rd;
  logic exp_err;
  logic [1:0] exp_cause;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m[i] = 32'h0;
    m[1] = 32'hFFCFFEDC; m[15] = 32'h1; m[105] = 32'h2402;
    m[31] = REV; m[28] = SLO; m[52] = SHI;
    exp_rd = 0; exp_err = 0; exp_cause = 0;
  endtask

  function automatic logic is_ro(int i);
    return i == 5 || (i >= 20 && i <= 27) || i == 30 || i == 31 || i == 56 || i == 57;
  endfunction

  task automatic op(input logic rd, input logic wr, input logic [AW-1:0] a,
                    input logic [31:0] d, input string tag);
    int i;
    logic inr, lk, we, re;
    logic [1:0] wc, rc;
    i = int'(a >> 2);
    inr = (a[1:0] == 2'b00) && (i < N);
    lk = (m[0] != MAGIC);
    we = 0; re = 0; wc = 0; rc = 0;
    if (wr) begin
      if (!inr) begin we = 1; wc = 2'b00; end
      else if (lk && i >= 1 && i <= 63) begin we = 1; wc = 2'b01; end
      else if (is_ro(i)) begin we = 1; wc = 2'b10; end
    end
    if (rd) begin
      if (!inr) begin re = 1; rc = 2'b00; end
      else if (i == 48) begin re = 1; rc = 2'b11; end
      exp_rd = inr ? m[i] : 32'h0;
    end
    exp_err = we || re;
    if (we) exp_cause = wc; else if (re) exp_cause = rc;
    if (wr && !we) m[i] = d;
    rd_en = rd; wr_en = wr; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    check(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
    check(err_pulse == exp_err, {tag, " err_pulse"}, 32'(err_pulse), 32'(exp_err));
    if (exp_err) check(err_cause == exp_cause, {tag, " err_cause"}, 32'(err_cause), 32'(exp_cause));
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(err_pulse == 0, "R1 reset err", 32'(err_pulse), 0);
    check(rdata == 0, "R1 reset rdata", rdata, 0);
    rst_n = 1;
    op(1, 0, 12'h004, 0, "R1 dflt 04");
    op(1, 0, 12'h03C, 0, "R1 dflt 3C");
    op(1, 0, 12'h1A4, 0, "R1 dflt 1A4");
    op(1, 0, 12'h008, 0, "R1 zero 08");
    op(1, 0, 12'h07C, 0, "R2 rev");
    op(1, 0, 12'h070, 0, "R2 strap lo");
    op(1, 0, 12'h0D0, 0, "R2 strap hi");
    op(0, 1, 12'h008, 32'h1111, "R4 locked wr");
    op(1, 0, 12'h008, 0, "R4 locked rb");
    op(0, 1, 12'h0FC, 32'h2222, "R4 locked top");
    op(0, 1, 12'h000, 32'h1688A8A9, "R3 key near");
    op(1, 0, 12'h000, 0, "R3 key rb");
    op(0, 1, 12'h008, 32'h3333, "R4 near key still locked");
    op(0, 1, 12'h014, 32'h4444, "R6 lock before ro");
    op(0, 1, 12'h000, MAGIC, "R10 key magic");
    op(0, 1, 12'h008, 32'hDEAD, "R10 unlocked next");
    op(1, 0, 12'h008, 0, "R10 unlocked rb");
    op(0, 1, 12'h0FC, 32'h5555, "R4 top open");
    op(1, 0, 12'h0FC, 0, "R4 top rb");
    op(0, 1, 12'h014, 32'h1, "R6 ro 14");
    op(0, 1, 12'h050, 32'h2, "R6 ro 50");
    op(0, 1, 12'h06C, 32'h3, "R6 ro 6C");
    op(0, 1, 12'h078, 32'h4, "R6 ro 78");
    op(0, 1, 12'h07C, 32'h5, "R6 ro 7C");
    op(0, 1, 12'h0E0, 32'h6, "R6 ro E0");
    op(0, 1, 12'h0E4, 32'h7, "R6 ro E4");
    op(1, 0, 12'h07C, 0, "R6 rev kept");
    op(1, 0, 12'h06C, 0, "R6 scratch kept");
    op(0, 1, 12'h04C, 32'h8, "R6 neighbour writable");
    op(1, 0, 12'h04C, 0, "R6 neighbour rb");
    op(0, 1, 12'h0C0, 32'h55, "R7 wo write");
    op(1, 0, 12'h0C0, 0, "R7 wo read");
    op(0, 1, 12'h000, 32'h0, "R3 relock");
    op(0, 1, 12'h100, 32'hABCD, "R5 open 100");
    op(1, 0, 12'h100, 0, "R5 rb 100");
    op(0, 1, 12'h1A4, 32'h77, "R5 open 1A4");
    op(1, 0, 12'h1A4, 0, "R5 rb 1A4");
    op(1, 0, 12'h1A8, 0, "R8 oor read");
    op(0, 1, 12'h1A8, 32'h9, "R8 oor write");
    op(1, 0, 12'hFFC, 0, "R8 oor top");
    op(1, 0, 12'h102, 0, "R8 misaligned rd");
    op(0, 1, 12'h101, 32'hF, "R8 misaligned wr");
    op(1, 0, 12'h100, 0, "R8 no alias");
    op(0, 1, 12'h104, 32'h1111, "R9 setup");
    op(1, 1, 12'h104, 32'h2222, "R9 rd+wr old");
    op(0, 0, 12'h0, 0, "R9 hold");
    op(1, 0, 12'h104, 0, "R9 new");
    op(1, 1, 12'h0C0, 32'h66, "R11 lock over wo");
    op(0, 0, 12'h0, 0, "R11 single pulse");
    op(0, 1, 12'h000, MAGIC, "R11 unlock");
    op(1, 1, 12'h0C0, 32'h66, "R11 wo only");
    op(1, 1, 12'h014, 32'h1, "R11 ro with read");
    op(1, 1, 12'h1AC, 32'h1, "R11 oor both");
    op(0, 0, 12'h0, 0, "R11 idle");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule